// File: doc/BRIEF.md
# Sleep Wake-Up Sequencer

This block governs the low-power state of a small pipelined processor core and how the core resumes from it. The core runs on a four-phase instruction cycle. This block owns the phase counter and publishes the current phase. When the core executes a sleep instruction, the block freezes the core until the pin-change interrupt source is flagged and enabled.

For crystal oscillators, the block waits out the oscillator start-up interval before it resumes. For RC oscillators it resumes at once. On wake it chooses one of two paths, based on the global interrupt enable sampled at the moment of wake:

- **In-line resume:** the core continues with the instruction that was prefetched before sleep.
- **Vectored resume:** the core executes that prefetched instruction while the return address is pushed and the global enable is cleared. A dummy cycle follows, with the program counter held, and then the counter is loaded with the interrupt vector.

The oscillator is modelled only by the clock input. One clock period is one oscillator period. The instruction decoder, datapath, stack and vector address itself live outside this block.

Top module: `sleep_wake_seq`

## Requirements
- R1: After reset, q_phase is 0, stall is 0, fetch_en is 1 and pc_load, vec_sel, dummy, push_ret and gie_clr are 0. q_phase then advances by one every clock and wraps from 3 (Q4) to 0 (Q1). All other outputs change only on the clock edge that ends a Q4 phase.
- R2: When sleep_exec is high at the end of a Q4 phase during normal running, and no wake condition is present, stall goes to 1 and fetch_en goes to 0 from the next Q1 on.
- R3: While asleep, the wake condition is pcif and pcie both high at the end of a Q4 phase. A raised pcif with pcie low leaves the core asleep.
- R4: For the crystal modes (osc_mode 2'b00, 2'b01, 2'b10), stall stays high for exactly OST_CLKS clocks after the edge that detects the wake.
- R5: For osc_mode 2'b11 (internal or external RC), stall falls at the Q1 right after the edge that detects the wake.
- R6: If gie was 0 at the wake-detect edge, the core resumes in-line: stall 0 and fetch_en 1, with pc_load, vec_sel, dummy, push_ret and gie_clr all 0.
- R7: If gie was 1 at the wake-detect edge, the sequence runs in two instruction cycles. First comes one cycle with fetch_en, push_ret and gie_clr at 1, in which the prefetched instruction executes. Then comes one dummy cycle with dummy, pc_load and vec_sel at 1, fetch_en at 0 (program counter held) and stall at 0. Normal running follows.
- R8: If the wake condition is present at the same Q4 edge that sees sleep_exec, the sleep acts as a no-op and stall stays 0.
- R9: The resume path is fixed by gie at the wake-detect edge. Changing gie during the start-up delay has no effect on it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock, one phase per period |
| rst_n | input | 1 | Active-low synchronous reset |
| sleep_exec | input | 1 | Sleep instruction executing in this cycle |
| osc_mode | input | 2 | Oscillator select: 00/01/10 crystal types, 11 RC |
| pcif | input | 1 | Pin-change interrupt flag |
| pcie | input | 1 | Pin-change interrupt enable |
| gie | input | 1 | Global interrupt enable |
| q_phase | output | 2 | Current phase, 0..3 for Q1..Q4 |
| stall | output | 1 | Core frozen (asleep or waiting for start-up) |
| fetch_en | output | 1 | Fetch and program-counter increment enable |
| pc_load | output | 1 | Load program counter at the end of the cycle |
| vec_sel | output | 1 | Select the interrupt vector as the PC source |
| dummy | output | 1 | Current cycle is the forced dummy cycle |
| push_ret | output | 1 | Push the return address this cycle |
| gie_clr | output | 1 | Clear the global interrupt enable this cycle |

## Verification
Every result except the phase count is due on the Q1 that follows the Q4 edge sampling the stimulus. The one exception is crystal wake-up, which adds exactly OST_CLKS clocks after the detecting edge. The bench's behavioural model applies each transition on the same edge. Outputs are compared at the falling edge of every clock, so a result one phase early or late shows up as a mismatch. Scenario checks add coarse windows that do not depend on the model: 0 to 3 clocks for an RC wake, and OST_CLKS to OST_CLKS+3 clocks for a crystal wake, measured from the falling edge where pcif is raised. They also check exact four-clock lengths for the push cycle and the dummy cycle.

// File: rtl/sleep_wake_seq.sv
module sleep_wake_seq #(
  parameter int OST_CLKS = 1024
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sleep_exec,
  input  logic [1:0] osc_mode,
  input  logic       pcif,
  input  logic       pcie,
  input  logic       gie,
  output logic [1:0] q_phase,
  output logic       stall,
  output logic       fetch_en,
  output logic       pc_load,
  output logic       vec_sel,
  output logic       dummy,
  output logic       push_ret,
  output logic       gie_clr
);
  localparam int OST_CYC = (OST_CLKS >= 8) ? OST_CLKS / 4 : 2;
  localparam int CW = $clog2(OST_CYC);

  typedef enum logic [2:0] {S_RUN, S_SLP, S_OST, S_EXE, S_DMY} st_t;

  st_t          st;
  logic [CW-1:0] ost_cnt;
  logic          vec_q;

  wire q4   = (q_phase == 2'd3);
  wire wake = pcif & pcie;
  wire rc   = &osc_mode;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_phase <= 2'd0;
      st      <= S_RUN;
      ost_cnt <= '0;
      vec_q   <= 1'b0;
    end else begin
      q_phase <= q_phase + 2'd1;
      if (q4) begin
        unique case (st)
          S_RUN: if (sleep_exec && !wake) st <= S_SLP;
          S_SLP: if (wake) begin
            vec_q   <= gie;
            ost_cnt <= '0;
            if (!rc)      st <= S_OST;
            else if (gie) st <= S_EXE;
            else          st <= S_RUN;
          end
          S_OST: begin
            if (ost_cnt == CW'(OST_CYC - 1)) st <= vec_q ? S_EXE : S_RUN;
            else ost_cnt <= ost_cnt + 1'b1;
          end
          S_EXE: st <= S_DMY;
          S_DMY: st <= S_RUN;
          default: st <= S_RUN;
        endcase
      end
    end
  end

  assign stall    = (st == S_SLP) || (st == S_OST);
  assign fetch_en = (st == S_RUN) || (st == S_EXE);
  assign push_ret = (st == S_EXE);
  assign gie_clr  = (st == S_EXE);
  assign dummy    = (st == S_DMY);
  assign pc_load  = (st == S_DMY);
  assign vec_sel  = (st == S_DMY);
endmodule

module sleep_wake_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sleep_exec,
  input logic [1:0] osc_mode,
  input logic       pcif,
  input logic       pcie,
  input logic       gie,
  input logic [1:0] q_phase,
  input logic       stall,
  input logic       fetch_en,
  input logic       pc_load,
  input logic       vec_sel,
  input logic       dummy,
  input logic       push_ret,
  input logic       gie_clr
);
  wire q4   = (q_phase == 2'd3);
  wire wake = pcif & pcie;
  wire run  = fetch_en & ~push_ret;

  a_r1_phase_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    q4 |=> (q_phase == 2'd0));
  a_r1_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
    !q4 |=> (q_phase == $past(q_phase) + 2'd1));
  a_r1_edge_only: assert property (@(posedge clk) disable iff (!rst_n)
    !q4 |=> $stable({stall, fetch_en, pc_load, vec_sel, dummy, push_ret, gie_clr}));
  a_r2_enter_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    (q4 && sleep_exec && !wake && run) |=> (stall && !fetch_en));
  a_r3_stay_asleep: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && q4 && !wake && osc_mode == 2'b11) |=> stall);
  a_r6_inline: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && q4 && wake && osc_mode == 2'b11 && !gie) |=> (fetch_en && !stall && !push_ret));
  a_r5_rc_vector: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && q4 && wake && osc_mode == 2'b11 && gie) |=> (push_ret && gie_clr));
  a_r7_dummy_next: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ret && q4) |=> dummy);
  a_r7_dummy_pc: assert property (@(posedge clk) disable iff (!rst_n)
    dummy |-> (pc_load && vec_sel && !fetch_en && !stall));
  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stall, push_ret, dummy}));
  a_r8_noop_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    (q4 && sleep_exec && wake && run) |=> !stall);
endmodule

bind sleep_wake_seq sleep_wake_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sleep_exec(sleep_exec), .osc_mode(osc_mode),
  .pcif(pcif), .pcie(pcie), .gie(gie), .q_phase(q_phase), .stall(stall),
  .fetch_en(fetch_en), .pc_load(pc_load), .vec_sel(vec_sel), .dummy(dummy),
  .push_ret(push_ret), .gie_clr(gie_clr)
);

// File: tb/sleep_wake_seq_test.sv
module sleep_wake_seq_test;
  localparam int OST = 1024;
  localparam int M_RUN = 0, M_SLP = 1, M_OST = 2, M_EXE = 3, M_DMY = 4;

  logic clk = 1'b0, rst_n = 1'b0, sleep_exec = 1'b0, pcif = 1'b0, pcie = 1'b1, gie = 1'b0;
  logic [1:0] osc_mode = 2'b11;
  logic [1:0] q_phase;
  logic stall, fetch_en, pc_load, vec_sel, dummy, push_ret, gie_clr;

  int tests = 0, fails = 0;
  int mst = M_RUN, mph = 0, mwait = 0;
  bit mvec = 1'b0;

  sleep_wake_seq #(.OST_CLKS(OST)) uut (
    .clk(clk), .rst_n(rst_n), .sleep_exec(sleep_exec), .osc_mode(osc_mode),
    .pcif(pcif), .pcie(pcie), .gie(gie), .q_phase(q_phase), .stall(stall),
    .fetch_en(fetch_en), .pc_load(pc_load), .vec_sel(vec_sel), .dummy(dummy),
    .push_ret(push_ret), .gie_clr(gie_clr));

  always #4 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: clock-level wait counter, state as integers
  always @(posedge clk) begin
    if (!rst_n) begin
      mst = M_RUN; mph = 0; mwait = 0; mvec = 1'b0;
    end else begin
      int old;
      old = mph;
      mph = (mph + 1) % 4;
      if (mst == M_OST) begin
        mwait--;
        if (mwait == 0) mst = mvec ? M_EXE : M_RUN;
      end else if (old == 3) begin
        case (mst)
          M_RUN: if (sleep_exec && !(pcif && pcie)) mst = M_SLP;
          M_SLP: if (pcif && pcie) begin
            mvec = gie;
            if (osc_mode != 2'b11) begin mst = M_OST; mwait = OST; end
            else mst = gie ? M_EXE : M_RUN;
          end
          M_EXE: mst = M_DMY;
          default: mst = M_RUN;
        endcase
      end
    end
  end

  always @(negedge clk) if (rst_n) begin
    chk("R1 q_phase", q_phase, mph);
    chk("R2 stall", stall, int'(mst == M_SLP || mst == M_OST));
    chk("R6 fetch_en", fetch_en, int'(mst == M_RUN || mst == M_EXE));
    chk("R7 push_ret", push_ret, int'(mst == M_EXE));
    chk("R7 gie_clr", gie_clr, int'(mst == M_EXE));
    chk("R7 dummy", dummy, int'(mst == M_DMY));
    chk("R7 pc_load", pc_load, int'(mst == M_DMY));
    chk("R7 vec_sel", vec_sel, int'(mst == M_DMY));
  end

  task automatic clocks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sleep_pulse();
    sleep_exec = 1'b1; clocks(4); sleep_exec = 1'b0;
  endtask

  task automatic wait_wake(output int n);
    n = 0;
    while (stall && n < 3000) begin clocks(1); n++; end
  endtask

  task automatic count_high(input bit which, output int n);
    n = 0;
    while ((which ? dummy : push_ret) && n < 20) begin clocks(1); n++; end
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n;
    clocks(3);
    chk("R1 reset q_phase", q_phase, 0);
    chk("R1 reset stall", stall, 0);
    chk("R1 reset fetch_en", fetch_en, 1);
    chk("R1 reset pc_load", pc_load, 0);
    chk("R1 reset push_ret", push_ret, 0);
    rst_n = 1'b1;
    clocks(9);

    // RC oscillator, in-line resume
    sleep_pulse(); clocks(8);
    chk("R2 asleep stall", stall, 1);
    chk("R2 asleep fetch_en", fetch_en, 0);
    pcif = 1'b1;
    wait_wake(n);
    chk("R5 rc wake within 3 clocks", int'(n <= 3), 1);
    chk("R6 inline fetch_en", fetch_en, 1);
    chk("R6 inline no push", push_ret, 0);
    clocks(4);
    chk("R6 inline no dummy", dummy, 0);
    pcif = 1'b0; clocks(8);

    // enable low blocks wake
    pcie = 1'b0; sleep_pulse(); pcif = 1'b1; clocks(40);
    chk("R3 no wake with pcie low", stall, 1);
    pcie = 1'b1; wait_wake(n);
    chk("R3 wake once enabled", stall, 0);
    pcif = 1'b0; clocks(8);

    // crystal, vectored resume
    osc_mode = 2'b01; gie = 1'b1;
    sleep_pulse(); clocks(6); pcif = 1'b1;
    wait_wake(n);
    chk("R4 crystal delay window", int'(n >= OST && n <= OST + 3), 1);
    count_high(1'b0, n);
    chk("R7 push cycle length", n, 4);
    count_high(1'b1, n);
    chk("R7 dummy cycle length", n, 4);
    chk("R7 back to run", fetch_en, 1);
    pcif = 1'b0; gie = 1'b0; clocks(8);

    // gie dropped during start-up: still vectors
    osc_mode = 2'b10; gie = 1'b1;
    sleep_pulse(); clocks(4); pcif = 1'b1; clocks(20); gie = 1'b0;
    wait_wake(n);
    chk("R9 latched gie vectors", push_ret, 1);
    clocks(4);
    chk("R9 dummy follows", dummy, 1);
    pcif = 1'b0; clocks(8);

    // gie raised during start-up: stays in-line
    osc_mode = 2'b00; gie = 1'b0;
    sleep_pulse(); clocks(4); pcif = 1'b1; clocks(20); gie = 1'b1;
    wait_wake(n);
    chk("R9 latched gie inline", push_ret, 0);
    pcif = 1'b0; gie = 1'b0; clocks(8);

    // RC with vectoring
    osc_mode = 2'b11; gie = 1'b1;
    sleep_pulse(); clocks(4); pcif = 1'b1;
    wait_wake(n);
    chk("R7 rc vector push", push_ret, 1);
    pcif = 1'b0; gie = 1'b0; clocks(12);

    // wake already pending: sleep is a no-op
    pcif = 1'b1; n = 0;
    sleep_exec = 1'b1;
    repeat (4) begin clocks(1); n += int'(stall); end
    sleep_exec = 1'b0;
    repeat (8) begin clocks(1); n += int'(stall); end
    chk("R8 no stall on pending wake", n, 0);
    pcif = 1'b0; clocks(8);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule